// File: doc/BRIEF.md
# Extended Mode Register Capture

This block sits on the memory-device side of a low-power DDR interface. Each rising clock edge it decodes the command pins and the bank address. When it sees an extended mode register write, it checks whether the write is legal. A legal write loads two small configuration fields from the address bus: the partial-array self-refresh area and the output drive strength. Both fields are held until the next legal write and feed the refresh and driver logic elsewhere on the die.

The block enforces the following preconditions on a write:
- every bank is idle;
- the clock enable was already high;
- no earlier write is still completing;
- every address bit outside the two fields is zero;
- the refresh code is not a reserved one.

An illegal attempt changes nothing in the stored fields and raises a one-cycle error pulse. A legal write opens a two-cycle completion window, during which a busy flag is high.

Top module: `extModeReg`

## Requirements
- R1: A write command is recognised at a rising clock edge only when csN, rasN, casN and weN are all 0 and bankAddr is 2'b10 (bit 1 high, bit 0 low). Any other pin combination leaves the fields unchanged and raises no error.
- R2: A write is accepted only when banksIdle is 1 and cke is 1 both in the command cycle and in the cycle before it. Otherwise the write is rejected and error is raised.
- R3: An accepted write stores the addr value sampled in the command cycle. The new field values appear on the outputs from the cycle after the command.
- R4: refreshArea is addr[2:0]: 3'b000 means full array, 3'b001 half, 3'b010 quarter. A write carrying codes 3'b011 to 3'b111 is rejected and error is raised.
- R5: driveStrength is addr[6:5]: 2'b00 means full, 2'b01 half, 2'b10 quarter, 2'b11 eighth. All four codes are accepted.
- R6: Reset is synchronous and active high. It sets refreshArea to 3'b000 and driveStrength to 2'b01, and clears busy and error.
- R7: A write with any of addr bits 3, 4 or 7 to 12 set is rejected and error is raised.
- R8: After an accepted write, busy is high for exactly two cycles. A write command arriving while busy is high is rejected and raises error.
- R9: A rejected write leaves refreshArea and driveStrength unchanged.
- R10: error is high for exactly the one cycle after each rejected write. Back-to-back rejected writes produce consecutive high cycles.
- R11: The register can be rewritten any number of times after reset. Each later legal write replaces both fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 2 | Bank address; 2'b10 selects the extended register |
| addr | input | 13 | Address bus carrying the field values |
| banksIdle | input | 1 | High when every bank is precharged and idle |
| refreshArea | output | 3 | Stored self-refresh area code |
| driveStrength | output | 2 | Stored drive strength code |
| busy | output | 1 | Write completion window in progress |
| error | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest case to reach is the clock-enable history. A write is rejected when cke is high in the command cycle but was low in the cycle before. The stimulus drops cke for exactly one cycle and issues the command on the very next edge. A second hard case is a command landing on either of the two busy cycles. The bench places commands one and two cycles after an accepted write, then one three cycles after, which must be accepted. Every reserved refresh code and every forbidden address bit is swept one at a time between legal writes, so a rejection is always seen against stored fields it could have altered.

// File: rtl/emrPkg.sv
package emrPkg;
  typedef struct packed {
    logic load;
  } emrStrobes_t;

  localparam logic [1:0] EMR_BANK_SEL = 2'b10;
endpackage

// File: rtl/emrDatapath.sv
module emrDatapath
  import emrPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AREA_W = 3,
  parameter int DRIVE_LSB = 5,
  parameter int DRIVE_W = 2,
  parameter int AREA_MAX = 2,
  parameter logic [2:0] RESET_AREA = 3'b000,
  parameter logic [1:0] RESET_DRIVE = 2'b01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  emrStrobes_t        strobes,
  output logic [AREA_W-1:0]  refreshArea,
  output logic [DRIVE_W-1:0] driveStrength,
  output logic               fieldsLegal
);
  localparam logic [ADDR_W-1:0] AREA_MASK  = ADDR_W'((1 << AREA_W) - 1);
  localparam logic [ADDR_W-1:0] DRIVE_MASK = ADDR_W'(((1 << DRIVE_W) - 1) << DRIVE_LSB);
  localparam logic [ADDR_W-1:0] KEEP_MASK  = AREA_MASK | DRIVE_MASK;

  logic [AREA_W-1:0]  areaIn;
  logic [DRIVE_W-1:0] driveIn;
  logic               reservedClear;
  logic               areaSupported;

  assign areaIn        = addr[AREA_W-1:0];
  assign driveIn       = addr[DRIVE_LSB +: DRIVE_W];
  assign reservedClear = ((addr & ~KEEP_MASK) == '0);
  assign areaSupported = (int'(areaIn) <= AREA_MAX);
  assign fieldsLegal   = reservedClear && areaSupported;

  always_ff @(posedge clk) begin
    if (rst) begin
      refreshArea   <= AREA_W'(RESET_AREA);
      driveStrength <= DRIVE_W'(RESET_DRIVE);
    end else if (strobes.load) begin
      refreshArea   <= areaIn;
      driveStrength <= driveIn;
    end
  end

  // Fields only move on a load strobe
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(refreshArea) && $stable(driveStrength));

  // A load never stores a reserved area code
  assert_area_legal_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (int'(refreshArea) <= AREA_MAX));
endmodule

// File: rtl/emrControl.sv
module emrControl
  import emrPkg::*;
#(
  parameter int BUSY_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cke,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic [1:0]  bankAddr,
  input  logic        banksIdle,
  input  logic        fieldsLegal,
  output emrStrobes_t strobes,
  output logic        busy,
  output logic        error
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] busyCnt;
  logic             ckePrev;
  logic             cmdSeen;
  logic             accept;

  assign cmdSeen = !csN && !rasN && !casN && !weN && (bankAddr == EMR_BANK_SEL);
  assign accept  = cmdSeen && banksIdle && cke && ckePrev && !busy && fieldsLegal;
  assign strobes.load = accept;
  assign busy    = (busyCnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busyCnt <= '0;
      ckePrev <= 1'b0;
      error   <= 1'b0;
    end else begin
      ckePrev <= cke;
      error   <= cmdSeen && !accept;
      if (accept) begin
        busyCnt <= CNT_LOAD;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  assert_busy_after_load_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> busy);

  assert_no_load_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !strobes.load);

  assert_load_needs_idle_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.load |-> banksIdle && cke);

  assert_error_follows_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    cmdSeen && !strobes.load |=> error);

  assert_no_error_without_cmd_R1: assert property (@(posedge clk) disable iff (rst)
    !cmdSeen |=> !error);
endmodule

// File: rtl/extModeReg.sv
module extModeReg
  import emrPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BUSY_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banksIdle,
  output logic [2:0]        refreshArea,
  output logic [1:0]        driveStrength,
  output logic              busy,
  output logic              error
);
  emrStrobes_t strobes;
  logic        fieldsLegal;

  emrControl #(.BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .banksIdle(banksIdle),
    .fieldsLegal(fieldsLegal), .strobes(strobes), .busy(busy), .error(error)
  );

  emrDatapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rst(rst), .addr(addr), .strobes(strobes),
    .refreshArea(refreshArea), .driveStrength(driveStrength),
    .fieldsLegal(fieldsLegal)
  );
endmodule

// File: tb/tb_extModeReg.sv
module tb_extModeReg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] bankAddr = 2'b00;
  logic [12:0] addr = '0;
  logic banksIdle = 1'b1;
  logic [2:0] refreshArea;
  logic [1:0] driveStrength;
  logic busy, error;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string curReq = "R6";

  // reference model state
  int mArea, mDrive, mBusy, mErr, mCkePrev;

  extModeReg dut (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .addr(addr), .banksIdle(banksIdle),
    .refreshArea(refreshArea), .driveStrength(driveStrength),
    .busy(busy), .error(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 5000", cycles);
      report();
    end
  end

  task automatic checkVal(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic modelStep();
    bit cmd, legal;
    cmd = !csN && !rasN && !casN && !weN && bankAddr == 2'b10;
    if (rst) begin
      mArea = 0; mDrive = 1; mBusy = 0; mErr = 0; mCkePrev = 0;
    end else begin
      legal = banksIdle && cke && mCkePrev == 1 && mBusy == 0 &&
              (addr & 13'h1F98) == 0 && addr[2:0] <= 3'd2;
      mErr = 0;
      if (cmd && legal) begin
        mArea = addr[2:0]; mDrive = addr[6:5]; mBusy = 2;
      end else begin
        if (mBusy > 0) mBusy--;
        if (cmd) mErr = 1;
      end
      mCkePrev = cke;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkVal("refreshArea", refreshArea, mArea);
    checkVal("driveStrength", driveStrength, mDrive);
    checkVal("busy", busy, mBusy != 0);
    checkVal("error", error, mErr);
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) begin
      csN = 1; rasN = 1; casN = 1; weN = 1; bankAddr = 2'b00; addr = '0;
      tick();
    end
  endtask

  task automatic cmd(logic [1:0] ba, logic [12:0] a);
    csN = 0; rasN = 0; casN = 0; weN = 0; bankAddr = ba; addr = a;
    tick();
  endtask

  initial begin
    // R6: reset state
    rst = 1; nop(3);
    rst = 0; cke = 1; nop(2);

    curReq = "R3"; cmd(2'b10, 13'h0041); nop(3);     // area half, drive quarter
    curReq = "R5";
    for (int d = 0; d < 4; d++) begin cmd(2'b10, 13'(d << 5)); nop(2); end
    curReq = "R11";
    for (int a = 0; a < 3; a++) begin cmd(2'b10, 13'(a | (a << 5))); nop(2); end

    curReq = "R8"; cmd(2'b10, 13'h0001); cmd(2'b10, 13'h0040); cmd(2'b10, 13'h0020);
    cmd(2'b10, 13'h0062); nop(3);

    curReq = "R1";
    cmd(2'b00, 13'h0002); cmd(2'b11, 13'h0002); cmd(2'b01, 13'h0002);
    rasN = 1; csN = 0; casN = 0; weN = 0; bankAddr = 2'b10; addr = 13'h0002; tick();
    csN = 1; rasN = 0; tick();
    nop(1);

    curReq = "R2"; banksIdle = 0; cmd(2'b10, 13'h0001); banksIdle = 1; nop(1);
    cke = 0; nop(1); cke = 1; cmd(2'b10, 13'h0001); nop(1);
    cke = 0; cmd(2'b10, 13'h0001); cke = 1; nop(2);

    curReq = "R4";
    for (int a = 3; a < 8; a++) begin cmd(2'b10, 13'(a)); nop(1); end
    curReq = "R7";
    for (int b = 3; b < 13; b++) begin
      if (b != 5 && b != 6) begin cmd(2'b10, 13'(1 << b) | 13'h0001); nop(1); end
    end
    curReq = "R9"; cmd(2'b10, 13'h0040); nop(2); cmd(2'b10, 13'h1005); nop(1);

    curReq = "R10"; cmd(2'b10, 13'h0007); cmd(2'b10, 13'h0010); cmd(2'b10, 13'h0003); nop(2);

    curReq = "R6"; cmd(2'b10, 13'h0062); rst = 1; nop(2); rst = 0; nop(2);
    report();
  end
endmodule